// File: doc/BRIEF.md
# Measurement Clock and Timestamp Sequencer

This block sets the pace of a loss-monitoring crate. It produces a periodic one-cycle measurement strobe. The strobe comes from one of three sources: a 1 MHz tick pulse divided by an 8-bit count, an external revolution marker taken as it arrives, or that marker divided by two. Three snapshot latch strobes (fast, slow and very slow) are derived by counting measurement strobes with separate 16-bit divisors. Each latch strobe captures the current timestamp and sets a sticky status bit. Any set status bit raises an interrupt.

A real-time clock keeps seconds and microseconds, driven by decoded 1 Hz and 1 MHz event pulses. On every measurement strobe a 64-bit record is written into an internal circular buffer. The record holds an 8-bit machine state, the seconds and the microseconds. The buffer pointer counts downward. An abort event sets a latched freeze flag that stops all measurement and latch strobes, so every history buffer in the crate stops at the same sample. While frozen, the buffer can be read out. A settings-update request is released in step with the next measurement strobe.

Configuration and commands use a word-wide register port. Register reads and buffer reads are combinational.

Top module: `meas_ts_sequencer`

## Requirements
- R1: Register 0 selects the source in bits [1:0] (0 = divided tick, 1 = marker, 2 = marker divided by two, 3 = none) and holds the tick divisor N in bits [15:8]. With source 0, `measStrobe` is high for one cycle, one cycle after every Nth `tickUs` pulse. N = 0 acts as 1.
- R2: With source 1, `measStrobe` is high the cycle after each `markerIn` pulse.
- R3: With source 2, `measStrobe` follows every second marker pulse. The first strobe after reset follows the second marker.
- R4: Registers 1, 2 and 3 hold the 16-bit fast, slow and very-slow divisors M (0 acts as 1). Each latch strobe is high together with every Mth measurement strobe.
- R5: Register 5 bits [2:0] are sticky fast/slow/very-slow status bits. Each is set the cycle after its latch strobe and cleared by writing 1 to it; a set wins over a simultaneous clear. `irq` is high while any bit is set.
- R6: A latch strobe captures the 64-bit timestamp {state[63:56], seconds[55:24], microseconds[23:0]}. The fast, slow and very-slow captures read as low/high word pairs at registers 9/10, 11/12 and 13/14.
- R7: `tickSec` increments the 32-bit seconds count (register 7) and clears the 24-bit microsecond count (register 8). Otherwise `tickUs` increments the microsecond count.
- R8: Each measurement strobe writes the current timestamp at the buffer pointer (register 6). The pointer then decrements, from all-ones at reset down to 0, and then wraps to all-ones.
- R9: Writing register 4 with bit 0 set pulses `dcReset` the next cycle. The pointer returns to all-ones after that pulse.
- R10: `abortEvt`, or a write of register 4 bit 1, sets `freeze`. A write of bit 2 clears it; set wins over clear. While frozen, no measurement or latch strobe is produced, including for a trigger in the cycle of the set. The tick count and the marker phase hold. Register 4 reads `freeze` in bit 0 and the pending update in bit 1.
- R11: A write of register 4 bit 6 makes `updStrobe` accompany the next measurement strobe.
- R12: Register 4 bits 3, 4 and 5 force the fast, slow and very-slow latch strobes the next cycle, unless frozen. Forcing does not disturb the divisor counts.
- R13: `bufRdData` shows the entry at `bufAddr` while frozen, and zero otherwise.
- R14: After reset, the source is 0 with tick divisor 21, the latch divisors are 50, 2500 and 50000, the pointer is all-ones, and status, freeze and all strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickUs | input | 1 | 1 MHz event pulse |
| tickSec | input | 1 | 1 Hz event pulse |
| markerIn | input | 1 | Revolution marker pulse |
| abortEvt | input | 1 | Abort event pulse |
| machState | input | 8 | Machine state stored in each record |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 4 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data |
| bufAddr | input | ADDR_W | Buffer read address |
| bufRdData | output | 64 | Buffer read data |
| measStrobe | output | 1 | Measurement strobe |
| fastLatch | output | 1 | Fast snapshot strobe |
| slowLatch | output | 1 | Slow snapshot strobe |
| vslowLatch | output | 1 | Very-slow snapshot strobe |
| updStrobe | output | 1 | Settings-update strobe |
| dcReset | output | 1 | Digitizer reset pulse |
| freeze | output | 1 | Abort-in-progress flag |
| irq | output | 1 | Snapshot interrupt |

## Verification
All strobe outputs and `freeze` are registered: they answer an input pulse or a command write one cycle later. Status bits, `irq`, captured timestamps, buffer entries, the pointer and the clock counts change one cycle after the strobe or event that causes them. Register and buffer reads follow the address within the cycle. The bench updates its model at each rising edge from the inputs it held across that edge, then compares every output 2 ns later, before it drives the next inputs. Each result is therefore compared in exactly the cycle in which it is due.

// File: rtl/mts_pkg.sv
package mts_pkg;
  localparam int REG_W   = 32;
  localparam int STATE_W = 8;
  localparam int SEC_W   = 32;
  localparam int US_W    = 24;
  localparam int TS_W    = STATE_W + SEC_W + US_W;
  localparam int NUM_LAT = 3;

  localparam logic [3:0] A_CFG  = 4'd0;
  localparam logic [3:0] A_DIV0 = 4'd1;
  localparam logic [3:0] A_CMD  = 4'd4;
  localparam logic [3:0] A_STAT = 4'd5;
  localparam logic [3:0] A_PTR  = 4'd6;
  localparam logic [3:0] A_SEC  = 4'd7;
  localparam logic [3:0] A_USEC = 4'd8;
  localparam logic [3:0] A_TS0  = 4'd9;

  localparam int C_DCR    = 0;
  localparam int C_ABORT  = 1;
  localparam int C_CLEAR  = 2;
  localparam int C_FORCE0 = 3;
  localparam int C_UPD    = 6;

  typedef enum logic [1:0] {SRC_TICK = 2'd0, SRC_MARK = 2'd1, SRC_HALF = 2'd2, SRC_OFF = 2'd3} src_e;

  typedef struct packed {
    logic               meas;
    logic [NUM_LAT-1:0] latch;
    logic               upd;
    logic               dcr;
  } strobes_t;
endpackage

// File: rtl/mts_ctrl.sv
module mts_ctrl import mts_pkg::*; #(
  parameter int TICK_DIV_W = 8,
  parameter int LAT_DIV_W  = 16,
  parameter logic [TICK_DIV_W-1:0] RST_TICK_DIV  = 21,
  parameter logic [LAT_DIV_W-1:0]  RST_FAST_DIV  = 50,
  parameter logic [LAT_DIV_W-1:0]  RST_SLOW_DIV  = 2500,
  parameter logic [LAT_DIV_W-1:0]  RST_VSLOW_DIV = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickUs,
  input  logic             markerIn,
  input  logic             abortEvt,
  input  logic             regWrEn,
  input  logic [3:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output strobes_t         str,
  output logic             freeze,
  output logic [REG_W-1:0] ctrlRd
);
  localparam logic [LAT_DIV_W-1:0] RST_DIV [NUM_LAT] = '{RST_FAST_DIV, RST_SLOW_DIV, RST_VSLOW_DIV};

  src_e                  srcSel;
  logic [TICK_DIV_W-1:0] tickDiv, tickCnt;
  logic [TICK_DIV_W:0]   effTick;
  logic                  phase, pending, pendingN;
  logic [LAT_DIV_W-1:0]  latDiv [NUM_LAT];
  logic [LAT_DIV_W-1:0]  latCnt [NUM_LAT];
  logic [NUM_LAT-1:0]    hit, latN;
  logic                  wrCmd, setAb, clrAb, freezeN, tickHit, trig, measN, updN;
  strobes_t              strN;
  logic                  unusedWr;

  assign unusedWr = ^regWrData;
  assign wrCmd    = regWrEn && (regAddr == A_CMD);
  assign setAb    = abortEvt | (wrCmd & regWrData[C_ABORT]);
  assign clrAb    = wrCmd & regWrData[C_CLEAR];
  assign freezeN  = setAb ? 1'b1 : (clrAb ? 1'b0 : freeze);

  assign effTick = (tickDiv == '0) ? {{TICK_DIV_W{1'b0}}, 1'b1} : {1'b0, tickDiv};
  assign tickHit = ({1'b0, tickCnt} + 1'b1) >= effTick;

  always_comb begin
    unique case (srcSel)
      SRC_TICK: trig = tickUs & tickHit;
      SRC_MARK: trig = markerIn;
      SRC_HALF: trig = markerIn & phase;
      default:  trig = 1'b0;
    endcase
  end
  assign measN = trig & ~freezeN;

  for (genvar g = 0; g < NUM_LAT; g++) begin : g_lat
    logic [LAT_DIV_W:0] effLat;
    assign effLat = (latDiv[g] == '0) ? {{LAT_DIV_W{1'b0}}, 1'b1} : {1'b0, latDiv[g]};
    assign hit[g]  = measN && (({1'b0, latCnt[g]} + 1'b1) >= effLat);
    assign latN[g] = hit[g] | (wrCmd & regWrData[C_FORCE0 + g] & ~freezeN);
  end

  assign updN     = measN & pending;
  assign pendingN = (pending & ~updN) | (wrCmd & regWrData[C_UPD]);

  always_comb begin
    strN.meas  = measN;
    strN.latch = latN;
    strN.upd   = updN;
    strN.dcr   = wrCmd & regWrData[C_DCR];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcSel  <= SRC_TICK;
      tickDiv <= RST_TICK_DIV;
      tickCnt <= '0;
      phase   <= 1'b0;
      freeze  <= 1'b0;
      pending <= 1'b0;
      str     <= '0;
      for (int i = 0; i < NUM_LAT; i++) begin
        latDiv[i] <= RST_DIV[i];
        latCnt[i] <= '0;
      end
    end else begin
      freeze  <= freezeN;
      pending <= pendingN;
      str     <= strN;
      if (srcSel == SRC_TICK && tickUs && !freezeN)
        tickCnt <= tickHit ? '0 : tickCnt + 1'b1;
      if (srcSel == SRC_HALF && markerIn && !freezeN)
        phase <= ~phase;
      for (int i = 0; i < NUM_LAT; i++) begin
        if (measN)
          latCnt[i] <= hit[i] ? '0 : latCnt[i] + 1'b1;
        if (regWrEn && regAddr == A_DIV0 + 4'(i))
          latDiv[i] <= regWrData[LAT_DIV_W-1:0];
      end
      if (regWrEn && regAddr == A_CFG) begin
        srcSel  <= src_e'(regWrData[1:0]);
        tickDiv <= regWrData[8 +: TICK_DIV_W];
      end
    end
  end

  always_comb begin
    ctrlRd = '0;
    if (regAddr == A_CFG) begin
      ctrlRd[1:0]              = srcSel;
      ctrlRd[8 +: TICK_DIV_W] = tickDiv;
    end else if (regAddr == A_CMD) begin
      ctrlRd[0] = freeze;
      ctrlRd[1] = pending;
    end
    for (int i = 0; i < NUM_LAT; i++)
      if (regAddr == A_DIV0 + 4'(i)) ctrlRd[LAT_DIV_W-1:0] = latDiv[i];
  end

  // R10: a frozen crate produces neither measurement nor latch strobes
  p_no_strobe_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> (!str.meas && str.latch == '0));
  // R10: the flag only drops after a clear command without a set
  p_freeze_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && $past(freeze)) |-> ($past(clrAb) && !$past(setAb)));
  // R11: the update strobe never appears without a measurement strobe
  p_upd_with_meas_r11: assert property (@(posedge clk) disable iff (!rst_n)
    str.upd |-> str.meas);
  // R12: a forced latch while not frozen shows up the next cycle
  p_force_latch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wrCmd && regWrData[C_FORCE0] && !freezeN) |=> str.latch[0]);
endmodule

// File: rtl/mts_data.sv
module mts_data import mts_pkg::*; #(
  parameter int ADDR_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobes_t           str,
  input  logic               freeze,
  input  logic               tickUs,
  input  logic               tickSec,
  input  logic [STATE_W-1:0] machState,
  input  logic               regWrEn,
  input  logic [3:0]         regAddr,
  input  logic [REG_W-1:0]   regWrData,
  input  logic [ADDR_W-1:0]  bufAddr,
  output logic [TS_W-1:0]    bufRdData,
  output logic [REG_W-1:0]   dataRd,
  output logic               irq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [TS_W-1:0]    mem [DEPTH];
  logic [TS_W-1:0]    tsLat [NUM_LAT];
  logic [TS_W-1:0]    tsNow;
  logic [SEC_W-1:0]   secCnt;
  logic [US_W-1:0]    usCnt;
  logic [ADDR_W-1:0]  ptr;
  logic [NUM_LAT-1:0] status, clrBits;
  logic               unusedWr;

  assign unusedWr = ^regWrData;
  assign tsNow    = {machState, secCnt, usCnt};
  assign clrBits  = (regWrEn && regAddr == A_STAT) ? regWrData[NUM_LAT-1:0] : '0;
  assign irq      = |status;

  always_ff @(posedge clk) begin
    if (str.meas) mem[ptr] <= tsNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secCnt <= '0;
      usCnt  <= '0;
      ptr    <= '1;
      status <= '0;
      for (int i = 0; i < NUM_LAT; i++) tsLat[i] <= '0;
    end else begin
      if (tickSec) begin
        secCnt <= secCnt + 1'b1;
        usCnt  <= '0;
      end else if (tickUs) begin
        usCnt <= usCnt + 1'b1;
      end
      if (str.dcr)       ptr <= '1;
      else if (str.meas) ptr <= ptr - 1'b1;
      status <= (status & ~clrBits) | str.latch;
      for (int i = 0; i < NUM_LAT; i++)
        if (str.latch[i]) tsLat[i] <= tsNow;
    end
  end

  assign bufRdData = freeze ? mem[bufAddr] : '0;

  always_comb begin
    dataRd = '0;
    unique case (regAddr)
      A_STAT:  dataRd[NUM_LAT-1:0] = status;
      A_PTR:   dataRd[ADDR_W-1:0]  = ptr;
      A_SEC:   dataRd              = secCnt;
      A_USEC:  dataRd[US_W-1:0]    = usCnt;
      default: dataRd = '0;
    endcase
    for (int i = 0; i < NUM_LAT; i++) begin
      if (regAddr == A_TS0 + 4'(2*i))     dataRd = tsLat[i][31:0];
      if (regAddr == A_TS0 + 4'(2*i + 1)) dataRd = tsLat[i][63:32];
    end
  end

  // R8: each measurement steps the pointer down by one (wrapping)
  p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(str.meas) && !$past(str.dcr)) |-> (ptr == $past(ptr) - 1'b1));
  // R9: the digitizer reset returns the pointer to all-ones
  p_ptr_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(str.dcr) |-> (&ptr));
  // R5: a latch strobe always leaves its status bit set
  p_status_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(str.latch) != '0) |-> (($past(str.latch) & ~status) == '0));
  // R7: the second event restarts the microsecond count
  p_us_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tickSec) |-> (usCnt == '0));
endmodule

// File: rtl/meas_ts_sequencer.sv
module meas_ts_sequencer import mts_pkg::*; #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickUs,
  input  logic              tickSec,
  input  logic              markerIn,
  input  logic              abortEvt,
  input  logic [7:0]        machState,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [ADDR_W-1:0] bufAddr,
  output logic [63:0]       bufRdData,
  output logic              measStrobe,
  output logic              fastLatch,
  output logic              slowLatch,
  output logic              vslowLatch,
  output logic              updStrobe,
  output logic              dcReset,
  output logic              freeze,
  output logic              irq
);
  strobes_t          str;
  logic [REG_W-1:0]  ctrlRd, dataRd;

  mts_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tickUs(tickUs), .markerIn(markerIn), .abortEvt(abortEvt),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .str(str), .freeze(freeze), .ctrlRd(ctrlRd)
  );

  mts_data #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rst_n(rst_n), .str(str), .freeze(freeze), .tickUs(tickUs), .tickSec(tickSec),
    .machState(machState), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .bufAddr(bufAddr), .bufRdData(bufRdData), .dataRd(dataRd), .irq(irq)
  );

  assign regRdData  = (regAddr <= A_CMD) ? ctrlRd : dataRd;
  assign measStrobe = str.meas;
  assign fastLatch  = str.latch[0];
  assign slowLatch  = str.latch[1];
  assign vslowLatch = str.latch[2];
  assign updStrobe  = str.upd;
  assign dcReset    = str.dcr;
endmodule

// File: tb/tb_meas_ts_sequencer.sv
module tb_meas_ts_sequencer;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 0, rst_n = 0;
  logic tickUs = 0, tickSec = 0, markerIn = 0, abortEvt = 0;
  logic [7:0] machState = 0;
  logic regWrEn = 0;
  logic [3:0] regAddr = 0;
  logic [31:0] regWrData = 0, regRdData;
  logic [ADDR_W-1:0] bufAddr = 0;
  logic [63:0] bufRdData;
  logic measStrobe, fastLatch, slowLatch, vslowLatch, updStrobe, dcReset, freeze, irq;

  always #4 clk = ~clk;

  meas_ts_sequencer #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .tickUs(tickUs), .tickSec(tickSec), .markerIn(markerIn),
    .abortEvt(abortEvt), .machState(machState), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .bufAddr(bufAddr), .bufRdData(bufRdData),
    .measStrobe(measStrobe), .fastLatch(fastLatch), .slowLatch(slowLatch), .vslowLatch(vslowLatch),
    .updStrobe(updStrobe), .dcReset(dcReset), .freeze(freeze), .irq(irq)
  );

  int nCmp = 0, nBad = 0, tcyc = 0;
  bit done = 0;
  int tickPer = 0, markPer = 0, secPer = 0;

  // behavioural reference state
  int mSrc = 0, mTickDiv = 21, mTickCnt = 0, mPhase = 0, mPend = 0, mStat = 0;
  int mDiv [3] = '{50, 2500, 50000};
  int mLatCnt [3] = '{0, 0, 0};
  bit mFreeze = 0, mMeas = 0, mUpd = 0, mDcr = 0;
  bit mLat [3] = '{0, 0, 0};
  bit [31:0] mSec = 0;
  bit [23:0] mUs = 0;
  bit [ADDR_W-1:0] mPtr = '1;
  logic [63:0] mMem [int];
  logic [63:0] mTs [3] = '{64'd0, 64'd0, 64'd0};

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] readModel(int a);
    case (a)
      0: return 32'((mTickDiv << 8) | mSrc);
      1, 2, 3: return 32'(mDiv[a-1]);
      4: return 32'((mPend << 1) | int'(mFreeze));
      5: return 32'(mStat);
      6: return 32'(mPtr);
      7: return mSec;
      8: return {8'd0, mUs};
      9, 11, 13: return mTs[(a-9)/2][31:0];
      10, 12, 14: return mTs[(a-10)/2][63:32];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string regTag(int a);
    case (a)
      0: return "R1 cfg";
      1, 2, 3: return "R4 div";
      4: return "R10 cmd";
      5: return "R5 status";
      6: return "R8 ptr";
      7, 8: return "R7 rtc";
      15: return "R14 idle";
      default: return "R6 stamp";
    endcase
  endfunction

  task automatic modelStep();
    bit wc, setA, clrA, nF, trig, nMeas, nUpd, hit;
    bit nLat [3];
    int clr, eff;
    logic [63:0] ts;
    wc = regWrEn && regAddr == 4'd4;
    ts = {machState, mSec, mUs};
    // timestamp side acts on the strobes already presented
    if (mMeas) begin mMem[int'(mPtr)] = ts; mPtr = mPtr - 1'b1; end
    if (mDcr) mPtr = '1;
    for (int i = 0; i < 3; i++) if (mLat[i]) mTs[i] = ts;
    clr = (regWrEn && regAddr == 4'd5) ? int'(regWrData[2:0]) : 0;
    mStat = (mStat & ~clr) | (int'(mLat[2]) << 2) | (int'(mLat[1]) << 1) | int'(mLat[0]);
    if (tickSec) begin mSec = mSec + 1; mUs = 0; end
    else if (tickUs) mUs = mUs + 1;
    // strobe generation
    setA = abortEvt || (wc && regWrData[1]);
    clrA = wc && regWrData[2];
    nF = setA ? 1'b1 : (clrA ? 1'b0 : mFreeze);
    eff = (mTickDiv == 0) ? 1 : mTickDiv;
    trig = 0;
    if (mSrc == 0 && tickUs) trig = (mTickCnt + 1 >= eff);
    if (mSrc == 1) trig = markerIn;
    if (mSrc == 2) trig = markerIn && mPhase == 1;
    if (mSrc == 0 && tickUs && !nF) mTickCnt = trig ? 0 : mTickCnt + 1;
    if (mSrc == 2 && markerIn && !nF) mPhase = 1 - mPhase;
    nMeas = trig && !nF;
    for (int i = 0; i < 3; i++) begin
      eff = (mDiv[i] == 0) ? 1 : mDiv[i];
      hit = nMeas && (mLatCnt[i] + 1 >= eff);
      if (nMeas) mLatCnt[i] = hit ? 0 : mLatCnt[i] + 1;
      nLat[i] = hit || (wc && regWrData[3+i] && !nF);
    end
    nUpd = nMeas && mPend == 1;
    mPend = ((mPend == 1 && !nUpd) || (wc && regWrData[6])) ? 1 : 0;
    mDcr = wc && regWrData[0];
    mMeas = nMeas; mUpd = nUpd; mFreeze = nF;
    for (int i = 0; i < 3; i++) mLat[i] = nLat[i];
    if (regWrEn) begin
      if (regAddr == 4'd0) begin mSrc = int'(regWrData[1:0]); mTickDiv = int'(regWrData[15:8]); end
      if (regAddr >= 4'd1 && regAddr <= 4'd3) mDiv[int'(regAddr)-1] = int'(regWrData[15:0]);
    end
  endtask

  task automatic compareAll();
    string st;
    st = (mSrc == 0) ? "R1 tick" : (mSrc == 1) ? "R2 marker" : (mSrc == 2) ? "R3 half" : "R10 off";
    chk(st, measStrobe, mMeas);
    chk("R4 fast", fastLatch, mLat[0]);
    chk("R4 slow", slowLatch, mLat[1]);
    chk("R4 vslow", vslowLatch, mLat[2]);
    chk("R11 update", updStrobe, mUpd);
    chk("R9 dcReset", dcReset, mDcr);
    chk("R10 freeze", freeze, mFreeze);
    chk("R5 irq", irq, mStat != 0);
    chk(regTag(int'(regAddr)), regRdData, readModel(int'(regAddr)));
    if (!mFreeze) chk("R13 unfrozen read", bufRdData, 0);
    else if (mMem.exists(int'(bufAddr))) chk("R8 R13 record", bufRdData, mMem[int'(bufAddr)]);
  endtask

  task automatic cyc();
    @(posedge clk);
    modelStep();
    #2;
    compareAll();
    tcyc++;
  endtask

  task automatic wr(int a, int d);
    regWrEn = 1; regAddr = 4'(a); regWrData = 32'(d);
    tickUs = 0; tickSec = 0; markerIn = 0;
    cyc();
    regWrEn = 0; regWrData = 0;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      tickUs   = (tickPer != 0) && (tcyc % tickPer == 0);
      markerIn = (markPer != 0) && (tcyc % markPer == 0);
      tickSec  = (secPer != 0) && (tcyc % secPer == secPer - 1);
      machState = 8'(tcyc * 7);
      regAddr  = 4'(tcyc % 16);
      bufAddr  = ADDR_W'(int'(mPtr) + 1 + (tcyc % 12));
      cyc();
    end
    tickUs = 0; markerIn = 0; tickSec = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nBad++; nCmp++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    // R14 reset state
    regAddr = 0; #1 chk("R14 cfg", regRdData, 32'h1500);
    regAddr = 1; #1 chk("R14 fast div", regRdData, 50);
    regAddr = 2; #1 chk("R14 slow div", regRdData, 2500);
    regAddr = 3; #1 chk("R14 vslow div", regRdData, 50000);
    regAddr = 6; #1 chk("R14 ptr", regRdData, DEPTH - 1);
    regAddr = 5; #1 chk("R14 status", regRdData, 0);
    chk("R14 strobes", {measStrobe, fastLatch, slowLatch, vslowLatch, updStrobe, dcReset, freeze, irq}, 0);

    tickPer = 2; secPer = 13; markPer = 5;
    wr(0, 3 << 8); wr(1, 2); wr(2, 3); wr(3, 0);
    run(40);
    wr(0, 0);           // divisor 0 acts as 1
    run(12);
    wr(0, 1);           // direct marker
    run(30);
    wr(0, 2);           // marker halved
    run(30);
    wr(4, 1 << 6);      // settings update request
    run(20);
    wr(4, 32'h38);      // force all latches
    chk("R12 force fast", fastLatch, 1);
    chk("R12 force slow", slowLatch, 1);
    chk("R12 force vslow", vslowLatch, 1);
    run(3);
    wr(5, 1); run(3);
    wr(5, 7); run(5);
    wr(4, 1);
    chk("R9 pulse", dcReset, 1);
    run(6);
    // abort with a marker in the same cycle
    markPer = 1;
    abortEvt = 1; markerIn = 1; cyc(); abortEvt = 0; markerIn = 0;
    run(24);
    wr(4, 32'h38);      // forced latches must stay quiet while frozen
    chk("R10 no forced latch", fastLatch, 0);
    run(2);
    wr(4, 6);           // set and clear together: stays frozen
    run(2);
    wr(4, 4);           // clear
    run(20);
    // pointer wrap with a marker on every cycle
    wr(0, 1);
    run(DEPTH + 8);
    wr(4, 2);           // freeze by command, then sweep the buffer
    run(40);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule